// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block runs an I2C master transaction from a small table of command words that software writes ahead of time. After a start pulse it walks the table from entry 0. Each entry is one of five operations: a start or repeated start, a write of N bytes, a read of N bytes, a stop, or an end marker. Write data comes from a transmit FIFO, one pop per byte. Read data goes to a receive FIFO, one push per byte. A separate bit-level bus engine does the actual signalling. The sequencer talks to it through a request/acknowledge handshake, one bus operation at a time.

Each entry carries its own acknowledge policy. For writes, the acknowledge bit returned by the slave can be compared with an expected value. For reads, the sequencer drives a programmed acknowledge value. A done flag per entry shows progress. Seven interrupt sources each have a raw flag, an enable and a write-one-to-clear input. A state code reports the byte-level phase. The block halts the list on any of these: an acknowledge mismatch, a receive timeout, lost arbitration, or an end entry.

Top module: `i2c_cmd_seq`

## Requirements
- R1: A command word has these fields: byte count in bits 7:0, acknowledge-check enable in bit 8, expected acknowledge in bit 9, acknowledge value to drive in bit 10, and opcode in bits 13:11. The opcodes are 0 start/restart, 1 write, 2 read, 3 stop and 4 end. A start pulse while idle clears all done flags and begins at entry 0. Each entry's done flag rises when that entry completes. After the last entry the block returns to idle.
- R2: A write entry pops one byte per byte transferred and sends its 8 data bits as TXBIT operations. The order is MSB first when tx_lsb is 0 and LSB first when tx_lsb is 1.
- R3: A read entry receives 8 RXBIT results per byte and pushes the byte. The first bit received lands in bit 7 when rx_lsb is 0 and in bit 0 when rx_lsb is 1. After each byte the entry drives its acknowledge value with a TXBIT operation.
- R4: After each written byte, the sequencer samples the acknowledge with an RXBIT operation. If checking is enabled and the sampled bit differs from the expected bit, the block raises int_raw[4], leaves the entry not done and goes idle without issuing further operations.
- R5: A start/restart entry issues bus operation 0 and raises int_raw[1] when it completes. A stop entry issues bus operation 1 and raises int_raw[2] when it completes.
- R6: An end entry raises int_raw[3], sets its done flag and halts the list, so later entries do not run.
- R7: int_raw[0] is raised after every byte's acknowledge phase completes.
- R8: During a read data bit, the sequencer counts the cycles spent waiting for the bus engine without a response. If that count reaches a non-zero tout_lim, it raises int_raw[5] and st_timeout, drops the request and goes idle.
- R9: If a data bit sent as 1 is sampled back as 0, the sequencer raises int_raw[6] and st_arb. The next cycle it drops be_req and goes idle.
- R10: A raw flag stays set until its int_clr bit is pulsed. int_status equals int_raw AND int_ena.
- R11: state_code reports the byte-level phase:
  - 0: idle or condition phases
  - 1: first written byte after a start
  - 2: acknowledge of that first byte
  - 3: receive data
  - 4: later transmit data
  - 5: acknowledge being sent
  - 6: acknowledge being awaited
- R12: Once be_req is raised, it stays high with be_op and be_txbit unchanged until be_ack, except when a timeout aborts the request. Bus operations are encoded 0 start, 1 stop, 2 TXBIT and 3 RXBIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin running the command table (ignored while busy) |
| cmd_we | input | 1 | Write enable for a command entry |
| cmd_idx | input | 4 | Command entry index |
| cmd_wdata | input | 32 | Command word |
| tx_lsb | input | 1 | Transmit LSB first |
| rx_lsb | input | 1 | Receive LSB first |
| tout_lim | input | 20 | Receive timeout limit in cycles, 0 disables |
| tx_data | input | 8 | Head of the transmit FIFO |
| tx_pop | output | 1 | Pop the transmit FIFO |
| rx_data | output | 8 | Received byte |
| rx_push | output | 1 | Push rx_data into the receive FIFO |
| be_req | output | 1 | Bus engine request |
| be_op | output | 2 | Bus engine operation |
| be_txbit | output | 1 | Bit to send (1 releases SDA) |
| be_ack | input | 1 | Bus engine completion |
| be_rxbit | input | 1 | Bit sampled by the bus engine |
| int_ena | input | 7 | Interrupt enables |
| int_clr | input | 7 | Write-one-to-clear pulses |
| int_raw | output | 7 | Raw interrupt flags |
| int_status | output | 7 | Masked interrupt flags |
| state_code | output | 3 | Byte-level phase code |
| busy | output | 1 | Command list running |
| st_timeout | output | 1 | Timeout status |
| st_arb | output | 1 | Arbitration-lost status |
| cmd_done | output | 16 | Per-entry done flags |

## Verification
The bench's bus engine answers each request three cycles after it rises. The fixed overheads per entry are one cycle of decode, one cycle to step to the next entry and one cycle to load each byte. Raw flags, done flags and status bits are registered and appear one edge after the completing acknowledge. A halt drops busy and be_req on that same edge. The bench therefore starts a list, waits on falling edges until busy is low, and only then samples every outcome, so no check depends on exact cycle counting. Handshake stability is watched cycle by cycle in the bench's engine model, and the state codes seen are recorded at each request.

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq #(
  parameter int NCMD = 16,
  parameter int TOW  = 20,
  localparam int PW  = $clog2(NCMD)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            cmd_we,
  input  logic [PW-1:0]   cmd_idx,
  input  logic [31:0]     cmd_wdata,
  input  logic            tx_lsb,
  input  logic            rx_lsb,
  input  logic [TOW-1:0]  tout_lim,
  input  logic [7:0]      tx_data,
  output logic            tx_pop,
  output logic [7:0]      rx_data,
  output logic            rx_push,
  output logic            be_req,
  output logic [1:0]      be_op,
  output logic            be_txbit,
  input  logic            be_ack,
  input  logic            be_rxbit,
  input  logic [6:0]      int_ena,
  input  logic [6:0]      int_clr,
  output logic [6:0]      int_raw,
  output logic [6:0]      int_status,
  output logic [2:0]      state_code,
  output logic            busy,
  output logic            st_timeout,
  output logic            st_arb,
  output logic [NCMD-1:0] cmd_done
);
  typedef enum logic [2:0] {S_IDLE, S_DEC, S_COND, S_LOAD, S_BIT, S_ACK, S_NEXT} st_t;
  localparam logic [2:0] OP_RS = 3'd0, OP_WR = 3'd1, OP_RD = 3'd2, OP_SP = 3'd3;

  st_t            st;
  logic [13:0]    tbl [NCMD];
  logic [PW-1:0]  pc;
  logic [2:0]     bitn;
  logic [7:0]     left, sh;
  logic           addr_ph;
  logic [TOW-1:0] tcnt;
  logic [6:0]     ev;

  wire [13:0] cw    = tbl[pc];
  wire [2:0]  op    = cw[13:11];
  wire        is_wr = (op == OP_WR);
  wire [2:0]  tsel  = tx_lsb ? bitn : 3'd7 - bitn;
  wire [2:0]  rsel  = rx_lsb ? bitn : 3'd7 - bitn;

  wire ev_byte   = (st == S_ACK) && be_ack;
  wire ev_start  = (st == S_COND) && be_ack && (op == OP_RS);
  wire ev_stop   = (st == S_COND) && be_ack && (op == OP_SP);
  wire ev_end    = (st == S_DEC) && (op > OP_SP);
  wire ev_ackerr = ev_byte && is_wr && cw[8] && (be_rxbit != cw[9]);
  wire ev_to     = (st == S_BIT) && !is_wr && !be_ack && (tout_lim != '0) && (tcnt == tout_lim);
  wire ev_arb    = (st == S_BIT) && is_wr && be_ack && be_txbit && !be_rxbit;

  assign ev         = {ev_arb, ev_to, ev_ackerr, ev_end, ev_stop, ev_start, ev_byte};
  assign int_status = int_raw & int_ena;
  assign busy       = (st != S_IDLE);
  assign be_req     = (st == S_COND) || (st == S_BIT) || (st == S_ACK);
  assign tx_pop     = (st == S_LOAD) && is_wr;
  assign rx_push    = ev_byte && !is_wr;
  assign rx_data    = sh;

  always_comb begin
    be_op      = 2'd0;
    be_txbit   = 1'b1;
    state_code = 3'd0;
    case (st)
      S_COND: be_op = (op == OP_RS) ? 2'd0 : 2'd1;
      S_LOAD: state_code = is_wr ? (addr_ph ? 3'd1 : 3'd4) : 3'd3;
      S_BIT: begin
        be_op      = is_wr ? 2'd2 : 2'd3;
        be_txbit   = is_wr ? sh[tsel] : 1'b1;
        state_code = is_wr ? (addr_ph ? 3'd1 : 3'd4) : 3'd3;
      end
      S_ACK: begin
        be_op      = is_wr ? 2'd3 : 2'd2;
        be_txbit   = is_wr ? 1'b1 : cw[10];
        state_code = is_wr ? (addr_ph ? 3'd2 : 3'd6) : 3'd5;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      pc <= '0;
      bitn <= '0;
      left <= '0;
      sh <= '0;
      addr_ph <= 1'b0;
      tcnt <= '0;
      cmd_done <= '0;
      int_raw <= '0;
      st_timeout <= 1'b0;
      st_arb <= 1'b0;
      for (int i = 0; i < NCMD; i++) tbl[i] <= '0;
    end else begin
      if (cmd_we) tbl[cmd_idx] <= cmd_wdata[13:0];
      int_raw <= (int_raw & ~int_clr) | ev;
      if (ev_to)  st_timeout <= 1'b1;
      if (ev_arb) st_arb <= 1'b1;
      case (st)
        S_IDLE: if (start) begin
          pc <= '0;
          cmd_done <= '0;
          st_timeout <= 1'b0;
          st_arb <= 1'b0;
          addr_ph <= 1'b0;
          st <= S_DEC;
        end
        S_DEC: begin
          if (op == OP_RS || op == OP_SP) st <= S_COND;
          else if (op == OP_WR || op == OP_RD) begin
            if (cw[7:0] == 8'd0) begin
              cmd_done[pc] <= 1'b1;
              st <= S_NEXT;
            end else begin
              left <= cw[7:0];
              st <= S_LOAD;
            end
          end else begin
            cmd_done[pc] <= 1'b1;
            st <= S_IDLE;
          end
        end
        S_COND: if (be_ack) begin
          cmd_done[pc] <= 1'b1;
          addr_ph <= (op == OP_RS);
          st <= S_NEXT;
        end
        S_LOAD: begin
          sh <= is_wr ? tx_data : 8'h00;
          bitn <= '0;
          tcnt <= '0;
          st <= S_BIT;
        end
        S_BIT: begin
          if (ev_arb || ev_to) st <= S_IDLE;
          else if (be_ack) begin
            if (!is_wr) sh[rsel] <= be_rxbit;
            bitn <= bitn + 3'd1;
            if (bitn == 3'd7) st <= S_ACK;
          end else if (!is_wr) tcnt <= tcnt + 1'b1;
        end
        S_ACK: if (be_ack) begin
          if (ev_ackerr) st <= S_IDLE;
          else begin
            addr_ph <= 1'b0;
            if (left == 8'd1) begin
              cmd_done[pc] <= 1'b1;
              st <= S_NEXT;
            end else begin
              left <= left - 8'd1;
              st <= S_LOAD;
            end
          end
        end
        S_NEXT: begin
          if (pc == PW'(NCMD - 1)) st <= S_IDLE;
          else begin
            pc <= pc + 1'b1;
            st <= S_DEC;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req && !be_ack && !ev_to) |=> (be_req && $stable(be_op) && $stable(be_txbit)));
  a_r9_arb_release: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb |=> (!be_req && !busy && st_arb));
  a_r4_ackerr_halt: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ackerr |=> (!busy && !be_req && int_raw[4]));
  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (cmd_done == '0 && busy));
  a_r2_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> !tx_pop);
  a_r8_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_to |=> (!busy && st_timeout));
endmodule

// File: tb/i2c_cmd_seq_tb.sv
module i2c_cmd_seq_tb_top;
  logic clk = 0, rst_n = 0, start = 0, cmd_we = 0;
  logic [3:0] cmd_idx = 0;
  logic [31:0] cmd_wdata = 0;
  logic tx_lsb = 0, rx_lsb = 0;
  logic [19:0] tout_lim = 20'd200;
  logic [7:0] tx_data = 0, rx_data;
  logic tx_pop, rx_push, be_req, be_txbit, busy, st_timeout, st_arb;
  logic [1:0] be_op;
  logic [6:0] int_ena = 0, int_clr = 0, int_raw, int_status;
  logic [2:0] state_code;
  logic [15:0] cmd_done;
  logic m_ack = 0, m_bit = 0;

  int checks = 0, fails = 0, cyc = 0;

  i2c_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_we(cmd_we), .cmd_idx(cmd_idx),
    .cmd_wdata(cmd_wdata), .tx_lsb(tx_lsb), .rx_lsb(rx_lsb), .tout_lim(tout_lim),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_data(rx_data), .rx_push(rx_push),
    .be_req(be_req), .be_op(be_op), .be_txbit(be_txbit), .be_ack(m_ack), .be_rxbit(m_bit),
    .int_ena(int_ena), .int_clr(int_clr), .int_raw(int_raw), .int_status(int_status),
    .state_code(state_code), .busy(busy), .st_timeout(st_timeout), .st_arb(st_arb),
    .cmd_done(cmd_done));

  always #2 clk = ~clk;

  localparam int LAT = 2;
  logic [7:0] slave_byte = 0, wire_bits = 0, seen = 0, rx_last = 0;
  logic slave_ack = 0, stall_rx = 0, arb_force = 0, log_clr = 0, ack_sent = 0, hs_err = 0;
  logic prev_req = 0, prev_ack = 0;
  logic [1:0] prev_op = 0;
  logic prev_tx = 0;
  logic [2:0] rbit = 0;
  int m_wait = 0, n_start = 0, n_stop = 0, n_pop = 0;

  always @(posedge clk) begin
    m_ack <= 1'b0;
    prev_req <= be_req; prev_ack <= m_ack; prev_op <= be_op; prev_tx <= be_txbit;
    if (prev_req && be_req && !prev_ack && (be_op != prev_op || be_txbit != prev_tx)) hs_err <= 1'b1;
    if (tx_pop) n_pop <= n_pop + 1;
    if (rx_push) rx_last <= rx_data;
    if (log_clr) begin
      seen <= 0; rbit <= 0; wire_bits <= 0;
    end else if (be_req && !m_ack && !(stall_rx && be_op == 2'd3 && state_code == 3'd3)) begin
      seen[state_code] <= 1'b1;
      if (m_wait == LAT) begin
        m_wait <= 0;
        m_ack <= 1'b1;
        case (be_op)
          2'd0: n_start <= n_start + 1;
          2'd1: n_stop <= n_stop + 1;
          2'd2: begin
            m_bit <= be_txbit & ~arb_force;
            if (state_code == 3'd1 || state_code == 3'd4) wire_bits <= {wire_bits[6:0], be_txbit};
            else ack_sent <= be_txbit;
          end
          default: begin
            if (state_code == 3'd3) begin
              m_bit <= slave_byte[3'd7 - rbit];
              rbit <= rbit + 3'd1;
            end else m_bit <= slave_ack;
          end
        endcase
      end else m_wait <= m_wait + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic prog(input int i, input int op, input int cnt, input bit chk, input bit ex, input bit av);
    @(negedge clk);
    cmd_we = 1; cmd_idx = 4'(i);
    cmd_wdata = {18'd0, 3'(op), av, ex, chk, 8'(cnt)};
    @(negedge clk);
    cmd_we = 0;
  endtask

  task automatic run();
    @(negedge clk); int_clr = 7'h7f; log_clr = 1;
    @(negedge clk); int_clr = 0; log_clr = 0; start = 1;
    @(negedge clk); start = 0;
    for (int k = 0; k < 5000 && busy; k++) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7 - i];
  endfunction

  // {read, lsb, ackval, data, expected}
  localparam logic [18:0] VEC [7] = '{
    {1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5},
    {1'b0, 1'b1, 1'b0, 8'h1E, 8'h78},
    {1'b0, 1'b0, 1'b0, 8'hC4, 8'hC4},
    {1'b0, 1'b1, 1'b0, 8'h01, 8'h80},
    {1'b1, 1'b0, 1'b1, 8'h96, 8'h96},
    {1'b1, 1'b1, 1'b0, 8'h96, 8'h69},
    {1'b1, 1'b1, 1'b1, 8'hE0, 8'h07}
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int p0, s0;
    repeat (3) @(negedge clk);
    check("R1 reset done", cmd_done, 0);
    check("R10 reset raw", int_raw, 0);
    check("R11 reset code", state_code, 0);
    check("R1 reset busy", busy, 0);
    rst_n = 1;
    @(negedge clk);

    foreach (VEC[v]) begin
      logic [18:0] e;
      e = VEC[v];
      if (!e[18]) begin
        tx_lsb = e[17]; tx_data = e[15:8];
        prog(0, 0, 0, 0, 0, 0); prog(1, 1, 1, 0, 0, 0); prog(2, 3, 0, 0, 0, 0); prog(3, 4, 0, 0, 0, 0);
        p0 = n_pop;
        run();
        check("R2 wire byte", wire_bits, e[7:0]);
        check("R2 one pop", n_pop - p0, 1);
        check("R5 R7 R6 raw flags", int_raw, 7'h0f);
        check("R1 done flags", cmd_done, 16'h000f);
      end else begin
        tx_lsb = 0; rx_lsb = e[17]; tx_data = 8'hA1; slave_byte = e[15:8];
        prog(0, 0, 0, 0, 0, 0); prog(1, 1, 1, 0, 0, 0); prog(2, 2, 1, 0, 0, e[16]);
        prog(3, 3, 0, 0, 0, 0); prog(4, 4, 0, 0, 0, 0);
        run();
        check("R3 rx byte", rx_last, e[7:0]);
        check("R3 ack driven", ack_sent, e[16]);
        check("R1 done flags read", cmd_done, 16'h001f);
      end
    end

    tx_lsb = 0; rx_lsb = 0; tx_data = 8'h5A; slave_byte = 8'h33;
    prog(0, 0, 0, 0, 0, 0); prog(1, 1, 2, 0, 0, 0); prog(2, 2, 1, 0, 0, 1);
    prog(3, 3, 0, 0, 0, 0); prog(4, 4, 0, 0, 0, 0);
    run();
    check("R11 codes seen", seen[6:1], 6'b111111);

    slave_ack = 1;
    prog(0, 0, 0, 0, 0, 0); prog(1, 1, 1, 1, 0, 0); prog(2, 3, 0, 0, 0, 0); prog(3, 4, 0, 0, 0, 0);
    s0 = n_stop;
    run();
    check("R4 ack error raw", int_raw[4], 1);
    check("R4 no stop", n_stop - s0, 0);
    check("R4 entry not done", cmd_done, 16'h0001);
    check("R7 byte done on error", int_raw[0], 1);

    prog(1, 1, 1, 0, 0, 0);
    run();
    check("R4 unchecked no error", int_raw[4], 0);
    check("R4 unchecked completes", cmd_done, 16'h000f);
    slave_ack = 0;

    stall_rx = 1; tout_lim = 20'd20;
    prog(0, 0, 0, 0, 0, 0); prog(1, 1, 1, 0, 0, 0); prog(2, 2, 1, 0, 0, 0); prog(3, 3, 0, 0, 0, 0);
    prog(4, 4, 0, 0, 0, 0);
    s0 = n_stop;
    run();
    check("R8 timeout raw", int_raw[5], 1);
    check("R8 timeout status", st_timeout, 1);
    check("R8 request dropped", be_req, 0);
    check("R8 no stop", n_stop - s0, 0);
    stall_rx = 0; tout_lim = 20'd200;

    arb_force = 1; tx_data = 8'hFF;
    prog(0, 0, 0, 0, 0, 0); prog(1, 1, 1, 0, 0, 0); prog(2, 3, 0, 0, 0, 0); prog(3, 4, 0, 0, 0, 0);
    s0 = n_stop;
    run();
    check("R9 arb raw", int_raw[6], 1);
    check("R9 arb status", st_arb, 1);
    check("R9 bus released", be_req, 0);
    check("R9 no stop", n_stop - s0, 0);
    arb_force = 0;

    prog(0, 0, 0, 0, 0, 0); prog(1, 4, 0, 0, 0, 0); prog(2, 1, 1, 0, 0, 0); prog(3, 3, 0, 0, 0, 0);
    p0 = n_pop;
    run();
    check("R6 end raw", int_raw[3], 1);
    check("R6 later entries skipped", n_pop - p0, 0);
    check("R1 done cleared on start", cmd_done, 16'h0003);
    check("R9 arb status cleared", st_arb, 0);

    int_ena = 7'h0c;
    @(negedge clk);
    check("R10 masked status", int_status, 7'h08);
    int_clr = 7'h08;
    @(negedge clk);
    int_clr = 0;
    @(negedge clk);
    check("R10 clear one flag", int_raw, 7'h02);
    check("R10 status after clear", int_status, 7'h00);
    check("R12 handshake stable", hs_err, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule